// File: doc/BRIEF.md
# Embedded Erase Sequencer

This block runs the self-timed erase of a small flash-style array, either over a chosen set of sectors or over the whole chip. A command decoder outside the block raises a one-cycle start pulse. For a sector erase it also passes a sector mask. The block works through each chosen sector in ascending index order. It first writes zero to every word of the sector, one word at a time, and reads each word back to confirm it holds zero. It then pulses the whole sector to all ones and reads every word back to confirm the erase. Sectors flagged in the protection mask are never touched. The host therefore never preprograms before an erase.

While the sequence runs, reads return a status word instead of array data. Bit 7 reads 0 as a data-polling flag. Bit 6 flips on every status read. Bit 5 reports a failed verify. The `ready` output is low for the same period. A sector erase can be paused and resumed by command. A chip erase ignores every command. Host writes are only taken while idle.

A verify that still fails after the allowed number of retries parks the block in a fault state, which only a reset clears. An asynchronous reset stops any erase at once and returns the block to array reads. Array contents are kept through a reset.

Top module: `erase_seq`

## Requirements
- R1: After reset, `ready`=1, `suspended`=0 and `err`=0.
- R2: While idle, a host write stores the bitwise AND of the old word and `host_wdata` at `addr`. The word address is {sector, word}, with the word index in the low log2(SECT_WORDS) bits.
- R3: A `start_sect` pulse while idle makes `ready` go low from the next clock edge. Each sector selected in `sect_sel` that is not protected then reads all ones (FFFFh) once `ready` returns high.
- R4: A `start_chip` pulse erases every sector whose `prot_mask` bit is 0 to all ones. Sectors whose bit is 1 keep their contents.
- R5: During a sector erase, a sector that is both selected and protected keeps its contents.
- R6: While `ready`=0 and not suspended, `rd_data` bit 7 reads 0 and bit 6 inverts after each cycle with `rd_en`=1.
- R7: When the erase completes, `ready` returns to 1 and `rd_data` again shows array contents at `addr`.
- R8: During a sector erase, `cmd_valid` with code B0h pauses the sequence on the next edge (`suspended`=1, `ready`=1, array reads allowed). Code 30h resumes it, and the erase then completes correctly.
- R9: During a chip erase, code B0h is ignored: `suspended` stays 0 and `ready` stays 0.
- R10: While busy, host writes and commands other than B0h have no effect on the array.
- R11: If a verify still fails after MAX_RETRY retries, `err` goes to 1, `ready` stays 0 and status bit 5 reads 1. This holds until reset.
- R12: Asserting `rst_n` low during an erase drives `ready`=1 and `err`=0 at once, without waiting for a clock edge.
- R13: Before the electrical erase, every word of a target sector is programmed to zero. A word the erase cannot raise therefore holds 0000h afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | ADDR_W | Word address for reads and host writes |
| host_we | input | 1 | Host program strobe (taken only when idle) |
| host_wdata | input | DATA_W | Host program data (ANDed into the word) |
| rd_en | input | 1 | Status read strobe (advances the toggle bit) |
| rd_data | output | DATA_W | Array word, or the status word while busy |
| start_sect | input | 1 | Start a sector erase over `sect_sel` |
| sect_sel | input | NUM_SECT | Sectors chosen for a sector erase |
| start_chip | input | 1 | Start a chip erase |
| prot_mask | input | NUM_SECT | Protected sectors (1 = skip) |
| cmd_valid | input | 1 | Command strobe during an operation |
| cmd_code | input | 8 | Command code (B0h suspend, 30h resume) |
| inject_stuck | input | 1 | Cell defect model: erase leaves word 0 of the sector unchanged |
| ready | output | 1 | 1 when idle or suspended |
| suspended | output | 1 | Sector erase is paused |
| err | output | 1 | Verify failure after all retries |

## Verification
Start pulses, commands and host writes take effect at the first rising edge after they are driven. The bench drives them at a falling edge, releases them one falling edge later and checks `ready` or `suspended` at that point. Status and array reads are combinational from `addr`, so they are sampled 1 ns after a falling edge. Each toggle step is checked one cycle after a read strobe. Completion depends on the sector count, so the bench polls `ready` against a cycle bound and only then compares the array with its own model. The reset abort is checked 1 ns after `rst_n` falls, before any clock edge.

// File: rtl/erase_pkg.sv
`timescale 1ns/1ps
package erase_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SCAN, S_PREP, S_PVER, S_ERS, S_EVER, S_SUSP, S_FAIL
    } seq_st_e;

    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
endpackage

// File: rtl/erase_mem.sv
`timescale 1ns/1ps
module erase_mem #(
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 4,
    parameter int DATA_W     = 16,
    localparam int SC_W      = $clog2(NUM_SECT),
    localparam int SW_W      = $clog2(SECT_WORDS),
    localparam int ADDR_W    = SC_W + SW_W,
    localparam int DEPTH     = NUM_SECT * SECT_WORDS
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              stuck,
    input  logic [SC_W-1:0]   op_sect,
    input  logic [SW_W-1:0]   op_word,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] op_rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    // Array contents survive reset, so an aborted erase leaves its traces.
    always_ff @(posedge clk) begin
        if (host_we)
            cell_q[host_addr] <= cell_q[host_addr] & host_wdata;
        if (prog_go)
            cell_q[{op_sect, op_word}] <= '0;
        if (erase_go) begin
            for (int w = 0; w < SECT_WORDS; w++) begin
                if (!(stuck && w == 0))
                    cell_q[{op_sect, SW_W'(w)}] <= '1;
            end
        end
    end

    assign host_rdata = cell_q[host_addr];
    assign op_rdata   = cell_q[{op_sect, op_word}];
endmodule

// File: rtl/erase_status.sv
`timescale 1ns/1ps
module erase_status (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_en,
    output logic toggle
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (!busy)
            tog_d = 1'b0;
        else if (rd_en)
            tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign toggle = tog_q;

    // R6: each status read while busy flips the toggle bit
    p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (toggle != $past(toggle)));
endmodule

// File: rtl/erase_seq.sv
`timescale 1ns/1ps
module erase_seq
    import erase_pkg::*;
#(
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int PROG_CYC   = 3,
    parameter int ERASE_CYC  = 5,
    parameter int MAX_RETRY  = 2,
    localparam int SC_W      = $clog2(NUM_SECT),
    localparam int SW_W      = $clog2(SECT_WORDS),
    localparam int ADDR_W    = SC_W + SW_W,
    localparam int CNT_MAX   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1),
    localparam int RT_W      = $clog2(MAX_RETRY + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                host_we,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                start_sect,
    input  logic [NUM_SECT-1:0] sect_sel,
    input  logic                start_chip,
    input  logic [NUM_SECT-1:0] prot_mask,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_code,
    input  logic                inject_stuck,
    output logic                ready,
    output logic                suspended,
    output logic                err
);
    typedef struct packed {
        seq_st_e             st;
        seq_st_e             ret;
        logic                chip;
        logic [NUM_SECT-1:0] tgt;
        logic [SC_W:0]       sect;
        logic [SW_W-1:0]     word;
        logic [CNT_W-1:0]    cnt;
        logic [RT_W-1:0]     retry;
        logic                err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic prog_go, erase_go, working, toggle;
    logic [DATA_W-1:0] arr_rdata, op_rdata, stat_word;

    assign working = (ctl_q.st == S_SCAN) || (ctl_q.st == S_PREP) || (ctl_q.st == S_PVER)
                  || (ctl_q.st == S_ERS)  || (ctl_q.st == S_EVER);

    always_comb begin
        ctl_d    = ctl_q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        if (working && !ctl_q.chip && cmd_valid && cmd_code == CMD_SUSPEND) begin
            ctl_d.ret = ctl_q.st;
            ctl_d.st  = S_SUSP;
        end else begin
            unique case (ctl_q.st)
                S_IDLE: begin
                    if (start_chip || start_sect) begin
                        ctl_d.chip = start_chip;
                        ctl_d.tgt  = (start_chip ? '1 : sect_sel) & ~prot_mask;
                        ctl_d.sect = '0;
                        ctl_d.st   = S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (ctl_q.sect == (SC_W+1)'(NUM_SECT)) begin
                        ctl_d.st = S_IDLE;
                    end else if (ctl_q.tgt[ctl_q.sect[SC_W-1:0]]) begin
                        ctl_d.word  = '0;
                        ctl_d.cnt   = '0;
                        ctl_d.retry = '0;
                        ctl_d.st    = S_PREP;
                    end else begin
                        ctl_d.sect = ctl_q.sect + 1'b1;
                    end
                end
                S_PREP: begin
                    if (ctl_q.cnt == CNT_W'(PROG_CYC - 1)) begin
                        prog_go   = 1'b1;
                        ctl_d.cnt = '0;
                        ctl_d.st  = S_PVER;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                S_PVER: begin
                    if (op_rdata != '0) begin
                        if (ctl_q.retry == RT_W'(MAX_RETRY)) begin
                            ctl_d.err = 1'b1;
                            ctl_d.st  = S_FAIL;
                        end else begin
                            ctl_d.retry = ctl_q.retry + 1'b1;
                            ctl_d.st    = S_PREP;
                        end
                    end else begin
                        ctl_d.retry = '0;
                        if (ctl_q.word == SW_W'(SECT_WORDS - 1)) begin
                            ctl_d.word = '0;
                            ctl_d.st   = S_ERS;
                        end else begin
                            ctl_d.word = ctl_q.word + 1'b1;
                            ctl_d.st   = S_PREP;
                        end
                    end
                end
                S_ERS: begin
                    if (ctl_q.cnt == CNT_W'(ERASE_CYC - 1)) begin
                        erase_go   = 1'b1;
                        ctl_d.cnt  = '0;
                        ctl_d.word = '0;
                        ctl_d.st   = S_EVER;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                S_EVER: begin
                    if (op_rdata != '1) begin
                        if (ctl_q.retry == RT_W'(MAX_RETRY)) begin
                            ctl_d.err = 1'b1;
                            ctl_d.st  = S_FAIL;
                        end else begin
                            ctl_d.retry = ctl_q.retry + 1'b1;
                            ctl_d.st    = S_ERS;
                        end
                    end else if (ctl_q.word == SW_W'(SECT_WORDS - 1)) begin
                        ctl_d.sect = ctl_q.sect + 1'b1;
                        ctl_d.st   = S_SCAN;
                    end else begin
                        ctl_d.word = ctl_q.word + 1'b1;
                    end
                end
                S_SUSP: begin
                    if (cmd_valid && cmd_code == CMD_RESUME)
                        ctl_d.st = ctl_q.ret;
                end
                S_FAIL: ctl_d.st = S_FAIL;
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= S_IDLE;
            ctl_q.ret <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    erase_mem #(
        .NUM_SECT(NUM_SECT), .SECT_WORDS(SECT_WORDS), .DATA_W(DATA_W)
    ) i_mem (
        .clk(clk),
        .host_we(host_we && ctl_q.st == S_IDLE),
        .host_addr(addr),
        .host_wdata(host_wdata),
        .prog_go(prog_go),
        .erase_go(erase_go),
        .stuck(inject_stuck),
        .op_sect(ctl_q.sect[SC_W-1:0]),
        .op_word(ctl_q.word),
        .host_rdata(arr_rdata),
        .op_rdata(op_rdata)
    );

    erase_status i_stat (
        .clk(clk), .rst_n(rst_n), .busy(!ready), .rd_en(rd_en), .toggle(toggle)
    );

    always_comb begin
        stat_word    = '0;
        stat_word[6] = toggle;
        stat_word[5] = ctl_q.err;
    end

    assign ready     = (ctl_q.st == S_IDLE) || (ctl_q.st == S_SUSP);
    assign suspended = (ctl_q.st == S_SUSP);
    assign err       = ctl_q.err;
    assign rd_data   = ready ? arr_rdata : stat_word;

    // R3: a start taken while idle makes the block busy on the next edge
    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !suspended && (start_sect || start_chip)) |=> !ready);
    // R6: the polling bit reads 0 whenever the block is busy
    p_poll_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !rd_data[7]);
    // R9: a suspend during a chip erase never pauses it
    p_no_susp_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.chip && !ready && cmd_valid && cmd_code == CMD_SUSPEND) |=> !suspended);
    // R11: the fault flag holds until reset and the retry count stays bounded
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !ready));
    p_retry_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.retry <= RT_W'(MAX_RETRY));
endmodule

// File: tb/test_erase_seq.sv
`timescale 1ns/1ps
module test_erase_seq;
    localparam int NS = 4, SW = 4, DW = 16, AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic host_we = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic start_sect = 1'b0, start_chip = 1'b0;
    logic [NS-1:0] sect_sel = '0, prot_mask = '0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic inject_stuck = 1'b0;
    logic ready, suspended, err;

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] mdl [NS*SW];

    always #2 clk = ~clk;

    erase_seq i_erase_seq (
        .clk(clk), .rst_n(rst_n), .addr(addr), .host_we(host_we),
        .host_wdata(host_wdata), .rd_en(rd_en), .rd_data(rd_data),
        .start_sect(start_sect), .sect_sel(sect_sel), .start_chip(start_chip),
        .prot_mask(prot_mask), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .inject_stuck(inject_stuck), .ready(ready), .suspended(suspended), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic host_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = AW'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        if (ready) mdl[a] = mdl[a] & d;
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0; #1;
    endtask

    task automatic start(input bit chip, input logic [NS-1:0] sel, input string req);
        @(negedge clk);
        start_chip = chip; start_sect = !chip; sect_sel = sel;
        @(negedge clk);
        start_chip = 1'b0; start_sect = 1'b0; #1;
        chk(ready == 1'b0, req, ready, 0);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 2000) begin step(); n++; end
        chk(ready == 1'b1, req, ready, 1);
    endtask

    task automatic erase_model(input logic [NS-1:0] tgt);
        for (int s = 0; s < NS; s++)
            if (tgt[s]) for (int w = 0; w < SW; w++) mdl[s*SW+w] = '1;
    endtask

    task automatic check_array(input string req);
        for (int a = 0; a < NS*SW; a++) begin
            @(negedge clk); addr = AW'(a); #1;
            chk(rd_data == mdl[a], req, rd_data, mdl[a]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; #3;
        rst_n = 1'b1; step();
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(suspended == 1'b0, "R1 suspended", suspended, 0);
        chk(err == 1'b0, "R1 err", err, 0);
    endtask

    task automatic t_chip_all();
        prot_mask = '0;
        start(1'b1, '0, "R3 busy after chip start");
        wait_ready("R7 chip erase completes");
        erase_model('1);
        check_array("R4 whole chip ones");
    endtask

    task automatic t_program();
        host_write(1, 16'h1234);
        host_write(1, 16'hFF0F);
        host_write(6, 16'hA5A5);
        host_write(13, 16'h00FF);
        host_write(9, 16'h5A5A);
        check_array("R2 host program AND");
    endtask

    task automatic t_sector();
        prot_mask = 4'b0010;
        start(1'b0, 4'b0011, "R3 busy after sector start");
        wait_ready("R7 sector erase completes");
        erase_model(4'b0001);
        check_array("R3 R5 sector erase result");
    endtask

    task automatic t_status();
        logic v1, v2;
        host_write(4, 16'h0000); host_write(8, 16'h1111);
        prot_mask = 4'b0000;
        start(1'b0, 4'b0100, "R3 busy for status");
        @(negedge clk); rd_en = 1'b1; #1;
        chk(rd_data[7] == 1'b0, "R6 polling bit low", rd_data[7], 0);
        v1 = rd_data[6];
        @(negedge clk); rd_en = 1'b0; #1;
        v2 = rd_data[6];
        chk(v2 == !v1, "R6 toggle flips", v2, !v1);
        @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; #1;
        chk(rd_data[6] == v1, "R6 toggle flips back", rd_data[6], v1);
        wait_ready("R7 completes after status reads");
        erase_model(4'b0100);
        addr = AW'(4); #1;
        chk(rd_data == mdl[4], "R7 array read after done", rd_data, mdl[4]);
        check_array("R3 sector 2 erased");
    endtask

    task automatic t_suspend();
        host_write(12, 16'h0F0F); host_write(3, 16'h3333);
        prot_mask = '0;
        start(1'b0, 4'b1000, "R3 busy before suspend");
        repeat (3) @(negedge clk);
        cmd(8'hB0);
        chk(suspended == 1'b1, "R8 suspended", suspended, 1);
        chk(ready == 1'b1, "R8 ready while suspended", ready, 1);
        repeat (20) step();
        chk(suspended == 1'b1, "R8 stays suspended", suspended, 1);
        addr = AW'(3); #1;
        chk(rd_data == mdl[3], "R8 array read while suspended", rd_data, mdl[3]);
        cmd(8'h30);
        chk(suspended == 1'b0 && ready == 1'b0, "R8 resumed busy", {suspended, ready}, 0);
        wait_ready("R8 completes after resume");
        erase_model(4'b1000);
        check_array("R8 erase result after resume");
    endtask

    task automatic t_chip_ignore();
        host_write(5, 16'h0000); host_write(10, 16'h1234);
        prot_mask = 4'b0110;
        start(1'b1, '0, "R3 busy chip");
        repeat (3) @(negedge clk);
        cmd(8'hB0);
        chk(suspended == 1'b0, "R9 suspend ignored", suspended, 0);
        chk(ready == 1'b0, "R9 still busy", ready, 0);
        wait_ready("R9 chip completes");
        erase_model(4'b1001);
        check_array("R4 protected sectors kept");
    endtask

    task automatic t_busy_ignore();
        host_write(2, 16'h2222);
        prot_mask = '0;
        start(1'b0, 4'b1000, "R3 busy for ignore");
        host_write(2, 16'h0000);
        cmd(8'h80);
        cmd(8'h30);
        chk(ready == 1'b0 && suspended == 1'b0, "R10 other commands ignored", {ready, suspended}, 0);
        wait_ready("R10 completes");
        erase_model(4'b1000);
        check_array("R10 busy writes ignored");
    endtask

    task automatic t_fail();
        int n = 0;
        host_write(8, 16'hFFFF);
        inject_stuck = 1'b1;
        prot_mask = '0;
        start(1'b0, 4'b0100, "R3 busy for fail");
        while (!err && n < 2000) begin step(); n++; end
        chk(err == 1'b1, "R11 err raised", err, 1);
        repeat (10) step();
        chk(ready == 1'b0 && err == 1'b1, "R11 stuck busy with err", {ready, err}, 2'b01);
        chk(rd_data[5] == 1'b1 && rd_data[7] == 1'b0, "R11 status err bit", rd_data[7:5], 3'b001);
        inject_stuck = 1'b0;
        @(negedge clk); rst_n = 1'b0; #1;
        chk(err == 1'b0 && ready == 1'b1, "R11 reset clears err", {err, ready}, 2'b01);
        @(negedge clk); rst_n = 1'b1; step();
        addr = AW'(8); #1;
        chk(rd_data == 16'h0000, "R13 preprogram left zero", rd_data, 0);
        addr = AW'(9); #1;
        chk(rd_data == 16'hFFFF, "R13 other words erased", rd_data, 16'hFFFF);
    endtask

    task automatic t_abort();
        prot_mask = '0;
        start(1'b1, '0, "R3 busy before abort");
        repeat (8) @(negedge clk);
        rst_n = 1'b0; #1;
        chk(ready == 1'b1, "R12 abort ready", ready, 1);
        chk(err == 1'b0 && suspended == 1'b0, "R12 abort flags", {err, suspended}, 0);
        @(negedge clk); rst_n = 1'b1;
        start(1'b1, '0, "R12 restart after abort");
        wait_ready("R12 restarted erase completes");
        erase_model('1);
        check_array("R12 re-erase result");
    endtask

    initial begin
        for (int a = 0; a < NS*SW; a++) mdl[a] = '1;
        t_reset();
        t_chip_all();
        t_program();
        t_sector();
        t_status();
        t_suspend();
        t_chip_ignore();
        t_busy_ignore();
        t_fail();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule